// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block is the command front end of a serial flash slave that owns the status byte and the rules that guard it. A host talks to it over SPI mode 0 (data sampled on the rising serial clock, shifted on the falling one, most significant bit first) while chip select is low. The block decodes a one-byte opcode and commits any state change only when chip select rises at exactly the right bit count. It answers status reads on the serial output for as long as the frame lasts.

The status byte carries a busy flag, a write-enable latch, three protection-level bits and a lock bit. A status write is honoured only after a write enable, and only outside the hardware-locked state. That state is set when the lock bit is 1 and the active-low protect pin is held low. An accepted status write starts a self-timed cycle of a programmable number of system clocks. During that cycle the busy flag reads 1 and every command except a status read is dropped. A whole-array erase request is reduced to a one-clock accept or reject pulse for the array logic.

The serial pins and the protect pin are brought into the system clock domain by synchronisers, so the serial clock must run well below the system clock.

Top module: `sfsr_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00 and the serial output is 0.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it. Each takes effect only when chip select rises after exactly 8 bits. A frame of 7 or 9 bits changes nothing.
- R3: Opcode 0x05 returns the status byte MSB first, starting with the bit sampled on the 9th rising clock. The byte repeats, refreshed, every 8 further clocks while chip select stays low. Its layout is bit 7 lock, bits 6:5 always 0, bits 4:2 protection level, bit 1 write-enable latch, bit 0 busy.
- R4: Opcode 0x01 followed by a data byte, with chip select rising after exactly 16 bits, copies data bits 7 and 4:2 into the lock and protection-level bits. Data bits 6, 5, 1 and 0 have no effect.
- R5: A status write while the write-enable latch is 0 changes nothing.
- R6: A status write whose frame is 15 or 17 bits long is discarded, and the write-enable latch keeps its value.
- R7: An accepted status write clears the write-enable latch at once and sets busy for TW_CYCLES system clocks, after which busy returns to 0.
- R8: While busy is 1, status reads work and show busy = 1, and every other opcode is ignored.
- R9: With the lock bit at 1 and wp_n low, a status write is not executed. With wp_n high the same write is executed.
- R10: Opcode 0xC7 in an 8-bit frame while idle gives a one-clock erase_go pulse if the latch is 1 and the protection level is 0, and clears the latch. In every other case it gives a one-clock erase_rej pulse and the latch is kept.
- R11: The serial output is 0 outside the data phase of a status read, including during every opcode byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_mosi | input | 1 | Serial data from host |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| spi_miso | output | 1 | Serial data to host |
| erase_go | output | 1 | One-clock pulse: bulk erase accepted |
| erase_rej | output | 1 | One-clock pulse: bulk erase refused |

## Verification
The commit logic is driven with frames of the right length and frames one bit short or one bit long. This separates a design that counts bits exactly from one that only looks at the opcode byte. Status writes carry data bytes with the ignored bit positions set, so a leak into the latch, busy or zero bits becomes visible. Erase requests are issued with the latch clear, with a non-zero protection level and in the allowed state, so accept and reject are told apart from each other and from silence. A single long status-read frame taken just after a write shows busy set in the first byte and cleared in a later one, which checks both the timed cycle and the streaming read.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;

    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_BULK = 8'hC7;

    localparam int BP_W = 3;

    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] lvl;
        logic            wel;
        logic            busy;
    } stat_t;

    function automatic logic [7:0] stat_to_byte(stat_t s);
        return {s.lock, 2'b00, s.lvl, s.wel, s.busy};
    endfunction

endpackage

// File: rtl/sfsr_sync.sv
module sfsr_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES:0] chain_d, chain_q;

        always_comb chain_d = {chain_q[STAGES-1:0], async_i[g]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {(STAGES+1){RST_VAL[g]}};
            else        chain_q <= chain_d;
        end

        assign level_o[g] = chain_q[STAGES-1];
        assign rise_o[g]  = chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall_o[g]  = ~chain_q[STAGES-1] & chain_q[STAGES];
    end

endmodule

// File: rtl/sfsr_frame.sv
module sfsr_frame #(
    parameter int BYTE_W = 8,
    parameter int MAXB   = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_act,
    input  logic                     sck_rise,
    input  logic                     mosi_s,
    output logic [$clog2(BYTE_W)-1:0] bit_idx,
    output logic [$clog2(MAXB+1)-1:0] nbyte,
    output logic [BYTE_W-1:0]        rx_byte,
    output logic [BYTE_W-1:0]        opcode
);

    localparam int IW = $clog2(BYTE_W);
    localparam int NW = $clog2(MAXB+1);

    typedef struct packed {
        logic [IW-1:0]     idx;
        logic [NW-1:0]     nb;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] op;
    } frame_t;

    frame_t fr_d, fr_q;

    always_comb begin
        fr_d = fr_q;
        if (!cs_act) begin
            fr_d = '0;
        end else if (sck_rise) begin
            fr_d.rx  = {fr_q.rx[BYTE_W-2:0], mosi_s};
            fr_d.idx = fr_q.idx + 1'b1;
            if (fr_q.idx == IW'(BYTE_W-1)) begin
                if (fr_q.nb != NW'(MAXB)) fr_d.nb = fr_q.nb + 1'b1;
                if (fr_q.nb == '0)        fr_d.op = {fr_q.rx[BYTE_W-2:0], mosi_s};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign bit_idx = fr_q.idx;
    assign nbyte   = fr_q.nb;
    assign rx_byte = fr_q.rx;
    assign opcode  = fr_q.op;

    // R6: byte count only falls back when the frame is closed
    a_r6_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.nb < $past(fr_q.nb)) |-> !$past(cs_act));

    // R2: opcode is frozen once the first byte has been taken
    a_r2_opcode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_act) && cs_act && $past(fr_q.nb) != '0) |-> $stable(fr_q.op));

endmodule

// File: rtl/sfsr_wtimer.sv
module sfsr_wtimer #(
    parameter int TW_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(TW_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)            cnt_d = CW'(TW_CYCLES);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R7: a new cycle is only requested while idle
    a_r7_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R7: count never leaves its window
    a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TW_CYCLES));

endmodule

// File: rtl/sfsr_tx.sv
module sfsr_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              sck_fall,
    input  logic              reload,
    input  logic [BYTE_W-1:0] stat_byte,
    output logic              miso
);

    logic [BYTE_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!rd_en)        sh_d = '0;
        else if (sck_fall) sh_d = reload ? stat_byte : {sh_q[BYTE_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign miso = sh_q[BYTE_W-1];

    // R11: output quiet one cycle after read phase is left
    a_r11_quiet_outside_read: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> !miso);

endmodule

// File: rtl/sfsr_ctrl.sv
module sfsr_ctrl
    import sfsr_pkg::*;
#(
    parameter int TW_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic wp_n,
    output logic spi_miso,
    output logic erase_go,
    output logic erase_rej
);

    localparam int BYTE_W = 8;
    localparam int MAXB   = 3;
    localparam int IW     = $clog2(BYTE_W);
    localparam int NW     = $clog2(MAXB + 1);
    localparam int NPIN   = 4;
    localparam int P_CS   = 0;
    localparam int P_SCK  = 1;
    localparam int P_MOSI = 2;
    localparam int P_WP   = 3;

    logic [NPIN-1:0] pin_lvl, pin_rise, pin_fall;

    sfsr_sync #(
        .WIDTH   (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1001)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({wp_n, spi_mosi, spi_sck, spi_cs_n}),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    logic cs_act, cs_close, sck_rise, sck_fall, mosi_s, wp_s;

    assign cs_act   = ~pin_lvl[P_CS];
    assign cs_close = pin_rise[P_CS];
    assign sck_rise = pin_rise[P_SCK] & cs_act;
    assign sck_fall = pin_fall[P_SCK] & cs_act;
    assign mosi_s   = pin_lvl[P_MOSI];
    assign wp_s     = pin_lvl[P_WP];

    logic [IW-1:0]     bit_idx;
    logic [NW-1:0]     nbyte;
    logic [BYTE_W-1:0] rx_byte, opcode;

    sfsr_frame #(
        .BYTE_W (BYTE_W),
        .MAXB   (MAXB)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_act   (cs_act),
        .sck_rise (sck_rise),
        .mosi_s   (mosi_s),
        .bit_idx  (bit_idx),
        .nbyte    (nbyte),
        .rx_byte  (rx_byte),
        .opcode   (opcode)
    );

    logic busy, start_cycle;

    sfsr_wtimer #(
        .TW_CYCLES (TW_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_cycle),
        .busy  (busy)
    );

    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] lvl;
        logic            wel;
        logic            go;
        logic            rej;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic len_one, len_two, hw_locked;

    assign len_one   = (nbyte == NW'(1)) && (bit_idx == '0);
    assign len_two   = (nbyte == NW'(2)) && (bit_idx == '0);
    assign hw_locked = ctl_q.lock && !wp_s;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.go    = 1'b0;
        ctl_d.rej   = 1'b0;
        start_cycle = 1'b0;
        if (cs_close && !busy) begin
            case (opcode)
                OP_WREN: if (len_one) ctl_d.wel = 1'b1;
                OP_WRDI: if (len_one) ctl_d.wel = 1'b0;
                OP_WRSR: begin
                    if (len_two && ctl_q.wel && !hw_locked) begin
                        ctl_d.lock  = rx_byte[7];
                        ctl_d.lvl   = rx_byte[4:2];
                        ctl_d.wel   = 1'b0;
                        start_cycle = 1'b1;
                    end
                end
                OP_BULK: begin
                    if (len_one) begin
                        if (ctl_q.wel && ctl_q.lvl == '0) begin
                            ctl_d.go  = 1'b1;
                            ctl_d.wel = 1'b0;
                        end else begin
                            ctl_d.rej = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    stat_t stat;
    logic  rd_en;

    assign stat  = '{lock: ctl_q.lock, lvl: ctl_q.lvl, wel: ctl_q.wel, busy: busy};
    assign rd_en = cs_act && (opcode == OP_RDSR) && (nbyte != '0);

    sfsr_tx #(
        .BYTE_W (BYTE_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .sck_fall  (sck_fall),
        .reload    (bit_idx == '0),
        .stat_byte (stat_to_byte(stat)),
        .miso      (spi_miso)
    );

    assign erase_go  = ctl_q.go;
    assign erase_rej = ctl_q.rej;

    // R4: protection bits move only together with the start of a timed cycle
    a_r4_bits_move_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ctl_q.lock, ctl_q.lvl}) |-> $rose(busy));

    // R7: latch already clear when the cycle begins
    a_r7_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !ctl_q.wel);

    // R9: no cycle starts out of the hardware-locked state
    a_r9_locked_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(ctl_q.lock && !wp_s));

    // R8: latch cannot be set while busy
    a_r8_wel_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.wel) |-> !$past(busy));

    // R10: accept pulse only from the permitted state
    a_r10_go_rules: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.go |-> $past(ctl_q.wel && ctl_q.lvl == '0 && !busy));

    // R10: pulses last one clock
    a_r10_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.go || ctl_q.rej) |=> !(ctl_q.go || ctl_q.rej));

endmodule

// File: tb/sfsr_ctrl_tb_top.sv
module sfsr_ctrl_tb_top;

    localparam int TW   = 600;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso, e_go, e_rej;

    always #4 clk = ~clk;

    sfsr_ctrl #(.TW_CYCLES(TW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_cs_n  (cs_n),
        .spi_sck   (sck),
        .spi_mosi  (mosi),
        .wp_n      (wp_n),
        .spi_miso  (miso),
        .erase_go  (e_go),
        .erase_rej (e_rej)
    );

    int n_chk = 0, n_bad = 0, n_go = 0, n_rej = 0;

    always @(negedge clk) begin
        if (e_go)  n_go++;
        if (e_rej) n_rej++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [79:0] word, input int nbits, output logic [79:0] got);
        got = '0;
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            mosi = word[nbits-1-i];
            wait_clk(HALF);
            got = {got[78:0], miso};
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        mosi = 1'b0;
        wait_clk(2 * HALF);
    endtask

    task automatic read_stat(output logic [7:0] st, output logic [7:0] op_phase);
        logic [79:0] g;
        frame(80'h0500, 16, g);
        st       = g[7:0];
        op_phase = g[15:8];
    endtask

    task automatic wait_idle(output logic [7:0] st);
        logic [7:0] ph;
        st = 8'h01;
        for (int k = 0; k < 20 && st[0]; k++) read_stat(st, ph);
    endtask

    typedef struct packed {
        logic [23:0] w;
        logic [4:0]  n;
        logic [7:0]  exp;
        logic        go;
        logic        rej;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{24'h000006, 5'd8,  8'h02, 1'b0, 1'b0},  // R2 latch set
        '{24'h000004, 5'd8,  8'h00, 1'b0, 1'b0},  // R2 latch clear
        '{24'h000003, 5'd7,  8'h00, 1'b0, 1'b0},  // R2 short frame
        '{24'h00000C, 5'd9,  8'h00, 1'b0, 1'b0},  // R2 long frame
        '{24'h00011C, 5'd16, 8'h00, 1'b0, 1'b0},  // R5 no latch
        '{24'h000006, 5'd8,  8'h02, 1'b0, 1'b0},  // R2
        '{24'h00008E, 5'd15, 8'h02, 1'b0, 1'b0},  // R6 15 bits
        '{24'h000238, 5'd17, 8'h02, 1'b0, 1'b0},  // R6 17 bits
        '{24'h00017F, 5'd16, 8'h1C, 1'b0, 1'b0},  // R4 masked bits, R7 latch cleared
        '{24'h0000C7, 5'd8,  8'h1C, 1'b0, 1'b1},  // R10 no latch
        '{24'h000006, 5'd8,  8'h1E, 1'b0, 1'b0},  // R2
        '{24'h0000C7, 5'd8,  8'h1E, 1'b0, 1'b1},  // R10 level nonzero
        '{24'h000180, 5'd16, 8'h80, 1'b0, 1'b0},  // R4 lock bit
        '{24'h000006, 5'd8,  8'h82, 1'b0, 1'b0},  // R2
        '{24'h0000C7, 5'd8,  8'h80, 1'b1, 1'b0}   // R10 accept
    };

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0]  st, ph;
        logic [79:0] g;
        int go0, rej0;

        wait_clk(5);
        chk("R1 miso in reset", {31'h0, miso}, 32'h0);
        rst_n = 1'b1;
        wait_clk(5);
        read_stat(st, ph);
        chk("R1 status after reset", {24'h0, st}, 32'h0);
        chk("R11 opcode phase quiet", {24'h0, ph}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            go0  = n_go;
            rej0 = n_rej;
            frame({56'h0, VECS[v].w}, int'(VECS[v].n), g);
            chk($sformatf("R11 miso during vector %0d", v), g[31:0], 32'h0);
            wait_idle(st);
            chk($sformatf("R2/R4/R5/R6 status vector %0d", v), {24'h0, st}, {24'h0, VECS[v].exp});
            chk($sformatf("R10 go pulses vector %0d", v), n_go - go0, {31'h0, VECS[v].go});
            chk($sformatf("R10 rej pulses vector %0d", v), n_rej - rej0, {31'h0, VECS[v].rej});
        end

        // R9: lock bit set, wp_n low blocks the write
        wp_n = 1'b0;
        frame(80'h06, 8, g);
        frame(80'h0100, 16, g);
        wait_idle(st);
        chk("R9 locked write blocked", {24'h0, st}, 32'h82);
        wp_n = 1'b1;
        wait_clk(8);
        frame(80'h0100, 16, g);
        wait_idle(st);
        chk("R9 unlocked write executes", {24'h0, st}, 32'h00);

        // R3 R7 R8: long read right after a write shows busy then idle
        frame(80'h06, 8, g);
        frame(80'h0108, 16, g);
        frame(80'h05_00000000_00000000, 72, g);
        chk("R7 R8 first streamed byte busy", {24'h0, g[63:56]}, 32'h09);
        chk("R3 R7 last streamed byte idle", {24'h0, g[7:0]}, 32'h08);
        chk("R3 streamed byte repeats", {24'h0, g[15:8]}, 32'h08);

        // R8: other opcodes ignored while busy
        frame(80'h06, 8, g);
        frame(80'h0100, 16, g);
        go0  = n_go;
        rej0 = n_rej;
        frame(80'h06, 8, g);
        frame(80'hC7, 8, g);
        read_stat(st, ph);
        chk("R8 busy seen by read", {31'h0, st[0]}, 32'h1);
        wait_idle(st);
        chk("R8 enable ignored while busy", {24'h0, st}, 32'h00);
        chk("R8 erase silent while busy", (n_go - go0) + (n_rej - rej0), 32'h0);

        // R7: busy length against TW
        frame(80'h06, 8, g);
        frame(80'h0110, 16, g);
        wait_clk(TW / 4);
        read_stat(st, ph);
        chk("R7 busy inside window", {24'h0, st}, 32'h11);
        wait_clk(TW);
        read_stat(st, ph);
        chk("R7 idle after window", {24'h0, st}, 32'h10);

        // R1: reset clears nonzero status
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        read_stat(st, ph);
        chk("R1 status after second reset", {24'h0, st}, 32'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule